// File: doc/BRIEF.md
# Phase-Frequency Comparator with Pump Override

This block sits in the digital part of a frequency synthesizer. It compares two single-cycle pulse streams that share one system clock. One stream comes from the reference divider, and its pulses are the comparison pulses. The other stream comes from the divided oscillator. From these two streams the block builds the charge-pump commands `up_o` and `dn_o`. The detector is a tri-state detector: it reacts to both phase and frequency error, because a pulse on one input holds its command until the matching pulse arrives on the other input.

A 3-bit mode code and a 2-bit pump current code are registered inside the block. Two mode codes give normal operation, in which the detector drives the pump. Other codes force the pump to sink, to source, or to stay off. The power-on code forces a sink and also releases the tuning output to high impedance. An in-lock flag watches the width of the pump activity in each comparison period. The flag is only meaningful in normal operation and reads 0 in every other mode.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: While `rst_ni` is low, the mode register holds 001 and the current register holds 00. As a result, `dn_o`=1, `up_o`=0, `tune_release_o`=1, `lock_o`=0 and `cur_sel_o`=00.
- R2: A comparison pulse sets the internal UP state and a divided pulse sets the internal DOWN state. Each state holds until both are set. When both are set, both are 1 for exactly one cycle and then both clear. Pulses that arrive in that clearing cycle are dropped.
- R3: When a comparison pulse and a divided pulse arrive in the same cycle, they cancel each other and the UP/DOWN state is left unchanged. With both states clear, such a pulse pair produces no output.
- R4: `mode_i` and `cur_code_i` take effect one cycle after they are presented. In modes 000, 100, 010 and 101, `up_o`/`dn_o` follow the detector state.
- R5: Mode 001 and mode 011 give `dn_o`=1 and `up_o`=0. Mode 111 gives `up_o`=1 and `dn_o`=0. Mode 110 gives `up_o`=`dn_o`=0.
- R6: `tune_release_o` is 1 exactly when the registered mode is 001.
- R7: `cur_sel_o` carries the registered current code, from 00 (lowest pump current) to 11 (highest pump current).
- R8: A comparison period ends on a comparison pulse and counts the cycles in which UP or DOWN is 1. After 16 consecutive periods with a count of 2 or less, in normal mode, `lock_o` rises in the cycle after the 16th closing pulse.
- R9: When the count of active cycles in a period reaches 3, the lock flag and the count of good periods clear on the next edge.
- R10: Outside modes 000 and 100, `lock_o` is 0 and the lock history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Comparison pulse, one cycle wide |
| div_pulse_i | input | 1 | Divided-oscillator pulse, one cycle wide |
| mode_i | input | 3 | Operating/test mode code |
| cur_code_i | input | 2 | Pump current code |
| up_o | output | 1 | Pump source command |
| dn_o | output | 1 | Pump sink command |
| cur_sel_o | output | 2 | Registered pump current select |
| tune_release_o | output | 1 | Tuning output released to high impedance |
| lock_o | output | 1 | In-lock flag |

## Verification
A UP or DOWN state that is stuck or lost shows at `up_o`/`dn_o` in the cycle after the pulse that should have set or cleared it. A stuck state also stretches the active width, so the lock flag fails to rise or drops within one comparison period. A wrong count of active cycles or of good periods shows only in the cycle in which `lock_o` changes. For that reason the bench compares every output against a cycle-accurate reference on every cycle. It also drives phase offsets that sit on both sides of the limit of 2 active cycles, and it sweeps all eight mode codes.

// File: rtl/pfd_pump_pkg.sv
package pfd_pump_pkg;
  typedef enum logic [2:0] {
    MODE_RUN_A   = 3'b000,
    MODE_POR     = 3'b001,
    MODE_AUX_A   = 3'b010,
    MODE_SINK    = 3'b011,
    MODE_RUN_B   = 3'b100,
    MODE_AUX_B   = 3'b101,
    MODE_OFF     = 3'b110,
    MODE_SOURCE  = 3'b111
  } pump_mode_e;

  function automatic logic mode_is_run(input logic [2:0] m);
    return (m == MODE_RUN_A) || (m == MODE_RUN_B);
  endfunction
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_pulse_i,
  input  logic div_pulse_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_q && dn_q) begin
      // clearing cycle wins, pulses in it are dropped
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (!(ref_pulse_i && div_pulse_i)) begin
      up_q <= up_q | ref_pulse_i;
      dn_q <= dn_q | div_pulse_i;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  a_r2_both_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && dn_q) |=> (!up_q && !dn_q));
  a_r3_coincide_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pulse_i && div_pulse_i && !up_q && !dn_q) |=> (!up_q && !dn_q));
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int MAX_ACT      = 2,
  parameter int LOCK_PERIODS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic ref_pulse_i,
  input  logic up_i,
  input  logic dn_i,
  output logic lock_o
);
  localparam int CW = $clog2(MAX_ACT + 2);
  localparam int GW = $clog2(LOCK_PERIODS + 1);
  localparam logic [CW-1:0] ACT_SAT = CW'(MAX_ACT + 1);
  localparam logic [CW-1:0] ACT_MAX = CW'(MAX_ACT);
  localparam logic [GW-1:0] GOOD_TGT = GW'(LOCK_PERIODS);

  logic [CW-1:0] cnt_q, cnt_next;
  logic [GW-1:0] good_q, good_inc;
  logic          lock_q, active, violate;

  assign active   = up_i | dn_i;
  assign cnt_next = (active && cnt_q != ACT_SAT) ? cnt_q + 1'b1 : cnt_q;
  assign violate  = cnt_next > ACT_MAX;
  assign good_inc = (good_q == GOOD_TGT) ? good_q : good_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (!enable_i) begin
      cnt_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (violate) begin
      cnt_q  <= ref_pulse_i ? '0 : cnt_next;
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (ref_pulse_i) begin
      cnt_q  <= '0;
      good_q <= good_inc;
      if (good_inc == GOOD_TGT) lock_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_next;
    end
  end

  assign lock_o = lock_q;

  a_r8_lock_on_period_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(ref_pulse_i));
  a_r9_wide_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && active && cnt_q == ACT_MAX) |=> !lock_q);
endmodule

// File: rtl/pump_override.sv
module pump_override
  import pfd_pump_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       det_up_i,
  input  logic       det_dn_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       release_o,
  output logic       run_o
);
  always_comb begin
    up_o = det_up_i;
    dn_o = det_dn_i;
    unique case (pump_mode_e'(mode_i))
      MODE_POR, MODE_SINK: begin up_o = 1'b0; dn_o = 1'b1; end
      MODE_SOURCE:         begin up_o = 1'b1; dn_o = 1'b0; end
      MODE_OFF:            begin up_o = 1'b0; dn_o = 1'b0; end
      default: ;
    endcase
  end

  assign release_o = (mode_i == MODE_POR);
  assign run_o     = mode_is_run(mode_i);
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl
  import pfd_pump_pkg::*;
#(
  parameter int MODE_W       = 3,
  parameter int CUR_W        = 2,
  parameter int MAX_ACT      = 2,
  parameter int LOCK_PERIODS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_pulse_i,
  input  logic              div_pulse_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CUR_W-1:0]  cur_code_i,
  output logic              up_o,
  output logic              dn_o,
  output logic [CUR_W-1:0]  cur_sel_o,
  output logic              tune_release_o,
  output logic              lock_o
);
  localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(MODE_POR);

  logic [MODE_W-1:0] mode_q;
  logic [CUR_W-1:0]  cur_q;
  logic det_up, det_dn, run, lock_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      cur_q  <= '0;
    end else begin
      mode_q <= mode_i;
      cur_q  <= cur_code_i;
    end
  end

  pfd_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_pulse_i (ref_pulse_i),
    .div_pulse_i (div_pulse_i),
    .up_o        (det_up),
    .dn_o        (det_dn)
  );

  pump_override u_ovr (
    .mode_i    (mode_q[2:0]),
    .det_up_i  (det_up),
    .det_dn_i  (det_dn),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .release_o (tune_release_o),
    .run_o     (run)
  );

  lock_detect #(.MAX_ACT(MAX_ACT), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (run),
    .ref_pulse_i (ref_pulse_i),
    .up_i        (det_up),
    .dn_i        (det_dn),
    .lock_o      (lock_raw)
  );

  assign lock_o    = lock_raw & run;
  assign cur_sel_o = cur_q;

  a_r5_forced_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b011) |=> (dn_o && !up_o));
  a_r5_forced_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b111) |=> (up_o && !dn_o));
  a_r10_lock_off_in_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b110) |=> !lock_o);
  a_r7_cur_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cur_sel_o == $past(cur_code_i)));
  a_r6_release_por: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b001) |=> tune_release_o);
endmodule

// File: tb/pfd_pump_ctrl_tb.sv
module pfd_pump_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_p = 1'b0, div_p = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [1:0] cur = 2'b00;
  logic up, dn, rel, lock;
  logic [1:0] cur_sel;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic m_up, m_dn, m_lock;
  logic [2:0] m_mode;
  logic [1:0] m_cur;
  int m_cnt, m_good;

  always #4 clk = ~clk;

  pfd_pump_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_pulse_i(ref_p), .div_pulse_i(div_p),
    .mode_i(mode), .cur_code_i(cur), .up_o(up), .dn_o(dn),
    .cur_sel_o(cur_sel), .tune_release_o(rel), .lock_o(lock)
  );

  function automatic logic f_run(input logic [2:0] m);
    return (m == 3'b000) || (m == 3'b100);
  endfunction

  function automatic logic f_up(input logic [2:0] m, input logic st);
    case (m)
      3'b001, 3'b011, 3'b110: return 1'b0;
      3'b111: return 1'b1;
      default: return st;
    endcase
  endfunction

  function automatic logic f_dn(input logic [2:0] m, input logic st);
    case (m)
      3'b001, 3'b011: return 1'b1;
      3'b111, 3'b110: return 1'b0;
      default: return st;
    endcase
  endfunction

  task automatic model_reset();
    m_up = 0; m_dn = 0; m_lock = 0; m_mode = 3'b001; m_cur = 2'b00;
    m_cnt = 0; m_good = 0;
  endtask

  task automatic model_step(input logic r, input logic d, input logic [2:0] m,
                            input logic [1:0] c);
    int cn;
    cn = m_cnt + ((m_up | m_dn) ? 1 : 0);
    if (cn > 3) cn = 3;
    if (!f_run(m_mode)) begin
      m_cnt = 0; m_good = 0; m_lock = 0;
    end else if (cn > 2) begin
      m_cnt = r ? 0 : cn; m_good = 0; m_lock = 0;
    end else if (r) begin
      m_cnt = 0;
      if (m_good < 16) m_good++;
      if (m_good == 16) m_lock = 1;
    end else m_cnt = cn;
    if (m_up && m_dn) begin
      m_up = 0; m_dn = 0;
    end else if (!(r && d)) begin
      m_up = m_up | r; m_dn = m_dn | d;
    end
    m_mode = m; m_cur = c;
  endtask

  task automatic chk(input string req, input string what, input logic [3:0] act,
                     input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "up_o", {3'b0, up}, {3'b0, f_up(m_mode, m_up)});
    chk(req, "dn_o", {3'b0, dn}, {3'b0, f_dn(m_mode, m_dn)});
    chk("R6", "tune_release_o", {3'b0, rel}, {3'b0, m_mode == 3'b001});
    chk("R7", "cur_sel_o", {2'b0, cur_sel}, {2'b0, m_cur});
    chk(req, "lock_o", {3'b0, lock}, {3'b0, m_lock & f_run(m_mode)});
  endtask

  task automatic step(input logic r, input logic d, input logic [2:0] m,
                      input logic [1:0] c, input string req);
    @(negedge clk);
    ref_p = r; div_p = d; mode = m; cur = c;
    @(posedge clk);
    #1;
    model_step(r, d, m, c);
    compare(req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    #20;
    // R1: reset state
    chk("R1", "dn_o", {3'b0, dn}, 4'h1);
    chk("R1", "up_o", {3'b0, up}, 4'h0);
    chk("R1", "tune_release_o", {3'b0, rel}, 4'h1);
    chk("R1", "lock_o", {3'b0, lock}, 4'h0);
    chk("R1", "cur_sel_o", {2'b0, cur_sel}, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 3'b001, 2'b00, "R1");

    // R4: enter normal mode, takes effect after one cycle
    step(0, 0, 3'b000, 2'b01, "R4");
    step(0, 0, 3'b000, 2'b01, "R4");
    // R2: ref then div, overlap cycle, clear
    step(1, 0, 3'b000, 2'b01, "R2");
    chk("R2", "up after ref", {3'b0, up}, 4'h1);
    step(0, 0, 3'b000, 2'b01, "R2");
    step(0, 1, 3'b000, 2'b01, "R2");
    chk("R2", "both set", {2'b0, up, dn}, 4'h3);
    step(0, 0, 3'b000, 2'b01, "R2");
    chk("R2", "both clear", {2'b0, up, dn}, 4'h0);
    // R2: pulse in clearing cycle dropped
    step(0, 1, 3'b000, 2'b01, "R2");
    step(1, 0, 3'b000, 2'b01, "R2");
    step(1, 0, 3'b000, 2'b01, "R2");
    chk("R2", "dropped in clear", {2'b0, up, dn}, 4'h0);
    // R3: coincident pulses
    step(1, 1, 3'b000, 2'b10, "R3");
    chk("R3", "coincide quiet", {2'b0, up, dn}, 4'h0);
    step(0, 1, 3'b000, 2'b10, "R3");
    step(1, 1, 3'b000, 2'b10, "R3");
    chk("R3", "coincide hold", {2'b0, up, dn}, 4'h1);
    step(1, 0, 3'b000, 2'b10, "R3");
    step(0, 0, 3'b000, 2'b10, "R3");

    // R8: locked run, div one cycle after ref (2 active cycles per period)
    for (int p = 0; p < 20; p++)
      for (int k = 0; k < 16; k++)
        step(k == 0, k == 1, (p % 2) ? 3'b100 : 3'b000, 2'b11, "R8");
    chk("R8", "lock after good periods", {3'b0, lock}, 4'h1);
    // R9: wide period clears lock
    for (int k = 0; k < 16; k++) step(k == 0, k == 3, 3'b000, 2'b11, "R9");
    chk("R9", "lock dropped", {3'b0, lock}, 4'h0);
    // R10: relock then leave normal mode
    for (int p = 0; p < 18; p++)
      for (int k = 0; k < 16; k++) step(k == 0, k == 1, 3'b000, 2'b00, "R8");
    step(0, 0, 3'b010, 2'b00, "R10");
    chk("R10", "lock off in test", {3'b0, lock}, 4'h0);

    // R5/R6: mode sweep with pulses
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 12; k++)
        step(k % 5 == 0, k % 7 == 2, 3'(m), 2'(k), "R5");

    // random phase: periodic ref with random div offset, random modes
    for (int p = 0; p < 150; p++) begin
      automatic int off = $urandom_range(0, 3);
      automatic logic [2:0] mm = ($urandom_range(0, 9) < 7) ?
                                 (($urandom_range(0, 1)) ? 3'b100 : 3'b000) : 3'($urandom);
      for (int k = 0; k < 16; k++)
        step(k == 0, k == off, mm, 2'($urandom), "R8");
    end
    // fully random pulses
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
           ($urandom_range(0, 3) != 0) ? 3'b000 : 3'($urandom), 2'($urandom), "R4");
    finish_run();
  end
endmodule